// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

The engine draws into a small on-chip frame buffer that is organised as rows of pixels with a programmable row pitch. It performs one of two jobs per launch. A fill paints every pixel of a destination rectangle with a foreground colour. A copy moves a source rectangle of the same size to a destination rectangle. Every pixel write passes through a bit mask.

Software programs a small set of registers through a single write port. The operation starts when the size register is written. The caller picks the horizontal and vertical stepping direction for each operation. When a direction runs backwards, the start coordinates name the far column or row. This lets a copy between overlapping rectangles produce the same result as copying an untouched snapshot of the source.

All register writes pass through a command queue. While an operation runs, new writes wait in the queue and are applied in order once the engine is idle. A busy flag and a free-entry count let software pace itself. A host pixel read port exposes the frame buffer contents.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy_o is 0, fifo_free_o equals the queue depth (16), and every frame-buffer pixel reads 0.
- R2: Register selects are: 0 destination start, 1 size (launches), 2 direction control, 3 source start, 4 pitch, 5 foreground colour, 6 write mask, 7 source select. Start registers carry x in bits 31:16 and y in bits 15:0. The size register carries width in bits 31:16 and height in bits 15:0. Pitch sits in bits 31:22. Colour, mask and source select use the low bits.
- R3: With source select 0 (fill), every pixel of the destination rectangle becomes the foreground colour and all other pixels keep their value. Pixel (x,y) lives at linear address y*pitch+x.
- R4: With source select 1 (copy), each destination pixel takes the source pixel at the same offset. Control bit 0 set steps x upward and clear steps it downward. Bit 1 set steps y upward and clear steps it downward. A reversed axis starts at min+size-1 for both source and destination.
- R5: An overlapping copy gives the snapshot-copy result when x steps upward exactly when destination x <= source x, and y steps upward exactly when destination y <= source y.
- R6: Only the bits set in the write mask change in a written pixel. This holds for both fill and copy.
- R7: Each pixel takes one read cycle and then one write cycle. A launch into an idle engine with an empty queue keeps busy_o high for exactly 2*width*height+1 cycles.
- R8: Register writes made while an operation runs are queued and applied in order after it ends. fifo_free_o reports 16 minus the number of pending entries.
- R9: A launch with zero width or zero height writes no pixel and keeps busy_o high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe (queued) |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| host_addr_i | input | 10 | Frame-buffer linear address for host read |
| host_pix_o | output | 8 | Pixel at host_addr_i (combinational) |
| busy_o | output | 1 | Operation running or queue not empty |
| fifo_free_o | output | 5 | Free command-queue entries |

## Verification
A corrupted walker coordinate or a wrong row-restart value shows up as displaced or missing pixels. The full frame-buffer compare after each operation catches this as soon as the operation ends. A wrong direction decision in an overlapping copy smears the source, and the bench catches it by comparing against a snapshot copy. A wrong per-pixel cycle count or a stuck queue pointer shows up at once as a busy duration that differs from 2*width*height+1, or as a free count that does not match the queued writes.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    REG_DST_XY   = 3'd0,
    REG_SIZE     = 3'd1,
    REG_CTRL     = 3'd2,
    REG_SRC_XY   = 3'd3,
    REG_PITCH    = 3'd4,
    REG_FG       = 3'd5,
    REG_MASK     = 3'd6,
    REG_SRC_SEL  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e    sel;
    logic [31:0] data;
  } reg_wr_t;

  localparam int COORD_W = 16;
  localparam int PITCH_W = 10;
endpackage

// File: rtl/blit_cmd_fifo.sv
module blit_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 35,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic [CW-1:0] free_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_push = push_i && (cnt != FULL);  // full: write dropped
  assign do_pop  = pop_i && (cnt != '0);
  assign dout_o  = mem[rptr];
  assign empty_o = (cnt == '0);
  assign free_o  = FULL - cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: a lone accepted push raises occupancy by one
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt != FULL) |=> (cnt == $past(cnt) + CW'(1)));
  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= FULL);
endmodule

// File: rtl/blit_fb.sv
module blit_fb #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] wdata_i,
  input  logic [AW-1:0]    src_addr_i,
  output logic [PIX_W-1:0] src_pix_o,
  input  logic [AW-1:0]    dst_addr_i,
  output logic [PIX_W-1:0] dst_pix_o,
  input  logic [AW-1:0]    host_addr_i,
  output logic [PIX_W-1:0] host_pix_o
);
  logic [PIX_W-1:0] mem [DEPTH];

  assign src_pix_o  = mem[src_addr_i];
  assign dst_pix_o  = mem[dst_addr_i];
  assign host_pix_o = mem[host_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker import blit_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int AW    = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic               step_right_i,
  input  logic               step_down_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic               copy_i,
  input  logic [PIX_W-1:0]   fg_i,
  input  logic [PIX_W-1:0]   mask_i,
  input  logic [PIX_W-1:0]   src_pix_i,
  input  logic [PIX_W-1:0]   dst_pix_i,
  output logic               running_o,
  output logic [AW-1:0]      src_addr_o,
  output logic [AW-1:0]      dst_addr_o,
  output logic               we_o,
  output logic [PIX_W-1:0]   wdata_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e                state;
  logic [COORD_W-1:0] dx, dy, sx, sy, dx0, sx0, wid, cols, rows;
  logic [PIX_W-1:0]   hold;
  logic [31:0]        dst_lin, src_lin;
  logic [COORD_W-1:0] x_step;

  assign x_step   = step_right_i ? COORD_W'(1) : '1;  // +1 or -1
  assign dst_lin  = 32'(dy) * 32'(pitch_i) + 32'(dx);
  assign src_lin  = 32'(sy) * 32'(pitch_i) + 32'(sx);
  assign dst_addr_o = dst_lin[AW-1:0];
  assign src_addr_o = src_lin[AW-1:0];
  assign running_o  = (state != ST_IDLE);
  assign we_o       = (state == ST_WR);
  assign wdata_o    = (dst_pix_i & ~mask_i) | (hold & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      {dx, dy, sx, sy, dx0, sx0, wid, cols, rows} <= '0;
      hold  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i && width_i != '0 && height_i != '0) begin
          dx <= dst_x_i;  dy <= dst_y_i;
          sx <= src_x_i;  sy <= src_y_i;
          dx0 <= dst_x_i; sx0 <= src_x_i;
          wid <= width_i; cols <= width_i; rows <= height_i;
          state <= ST_RD;
        end
        ST_RD: begin
          hold  <= copy_i ? src_pix_i : fg_i;
          state <= ST_WR;
        end
        ST_WR: begin
          state <= ST_RD;
          if (cols == COORD_W'(1)) begin
            if (rows == COORD_W'(1)) begin
              state <= ST_IDLE;
            end else begin
              rows <= rows - COORD_W'(1);
              cols <= wid;
              dx   <= dx0;
              sx   <= sx0;
              dy   <= step_down_i ? dy + COORD_W'(1) : dy - COORD_W'(1);
              sy   <= step_down_i ? sy + COORD_W'(1) : sy - COORD_W'(1);
            end
          end else begin
            cols <= cols - COORD_W'(1);
            dx   <= dx + x_step;
            sx   <= sx + x_step;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a write cycle is always followed by a read cycle
  a_r7_write_pace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  a_r7_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !running_o);
  // R9: empty rectangle never enters the pixel loop
  a_r9_empty_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (width_i == '0 || height_i == '0)) |=> !running_o);
endmodule

// File: rtl/blit_engine.sv
module blit_engine import blit_pkg::*; #(
  parameter int PIX_W      = 8,
  parameter int FB_DEPTH   = 1024,
  parameter int FIFO_DEPTH = 16,
  localparam int AW        = $clog2(FB_DEPTH),
  localparam int FW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic [AW-1:0]    host_addr_i,
  output logic [PIX_W-1:0] host_pix_o,
  output logic             busy_o,
  output logic [FW-1:0]    fifo_free_o
);
  localparam int RW = $bits(reg_wr_t);

  reg_wr_t             push_ent, head;
  logic [RW-1:0]       head_raw;
  logic                fifo_empty, pop, start, running;
  logic [COORD_W-1:0]  dst_x, dst_y, src_x, src_y;
  logic [1:0]          ctrl;
  logic [PITCH_W-1:0]  pitch;
  logic [PIX_W-1:0]    fg, mask;
  logic                copy_sel;
  logic                fb_we;
  logic [AW-1:0]       src_addr, dst_addr;
  logic [PIX_W-1:0]    src_pix, dst_pix, fb_wdata;

  assign push_ent = '{sel: reg_sel_e'(reg_sel_i), data: reg_wdata_i};
  assign head     = reg_wr_t'(head_raw);
  assign pop      = !running && !fifo_empty;
  assign start    = pop && (head.sel == REG_SIZE);
  assign busy_o   = running || !fifo_empty;

  blit_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(RW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (reg_we_i),
    .din_i  (push_ent),
    .pop_i  (pop),
    .dout_o (head_raw),
    .empty_o(fifo_empty),
    .free_o (fifo_free_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {dst_x, dst_y, src_x, src_y} <= '0;
      ctrl     <= 2'b11;
      pitch    <= '0;
      fg       <= '0;
      mask     <= '1;
      copy_sel <= 1'b0;
    end else if (pop) begin
      case (head.sel)
        REG_DST_XY:  {dst_x, dst_y} <= head.data;
        REG_CTRL:    ctrl     <= head.data[1:0];
        REG_SRC_XY:  {src_x, src_y} <= head.data;
        REG_PITCH:   pitch    <= head.data[31:22];
        REG_FG:      fg       <= head.data[PIX_W-1:0];
        REG_MASK:    mask     <= head.data[PIX_W-1:0];
        REG_SRC_SEL: copy_sel <= head.data[0];
        default: ;
      endcase
    end
  end

  blit_walker #(.PIX_W(PIX_W), .AW(AW)) u_walker (
    .clk_i, .rst_ni,
    .start_i     (start),
    .width_i     (head.data[31:16]),
    .height_i    (head.data[15:0]),
    .dst_x_i     (dst_x),
    .dst_y_i     (dst_y),
    .src_x_i     (src_x),
    .src_y_i     (src_y),
    .step_right_i(ctrl[0]),
    .step_down_i (ctrl[1]),
    .pitch_i     (pitch),
    .copy_i      (copy_sel),
    .fg_i        (fg),
    .mask_i      (mask),
    .src_pix_i   (src_pix),
    .dst_pix_i   (dst_pix),
    .running_o   (running),
    .src_addr_o  (src_addr),
    .dst_addr_o  (dst_addr),
    .we_o        (fb_we),
    .wdata_o     (fb_wdata)
  );

  blit_fb #(.PIX_W(PIX_W), .DEPTH(FB_DEPTH)) u_fb (
    .clk_i, .rst_ni,
    .we_i       (fb_we),
    .waddr_i    (dst_addr),
    .wdata_i    (fb_wdata),
    .src_addr_i (src_addr),
    .src_pix_o  (src_pix),
    .dst_addr_i (dst_addr),
    .dst_pix_o  (dst_pix),
    .host_addr_i(host_addr_i),
    .host_pix_o (host_pix_o)
  );

  // R8: any accepted register write is visible as busy next cycle
  a_r8_busy_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> busy_o);
  // R6: masked-off bits of a written pixel keep their old value
  a_r6_mask_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_we |-> ((fb_wdata & ~mask) == (dst_pix & ~mask)));
  // R8: no register changes while a rectangle is in flight
  a_r8_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running)) |-> ($stable(fg) && $stable(mask) && $stable(pitch)));
endmodule

// File: tb/blit_engine_bench.sv
`timescale 1ns/1ps
module blit_engine_bench;
  localparam int DEPTH = 1024;
  localparam int PITCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_pix;
  logic        busy;
  logic [4:0]  fifo_free;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] snap  [DEPTH];

  always #2.5 clk = ~clk;

  blit_engine u_blit_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .host_addr_i(host_addr), .host_pix_o(host_pix),
    .busy_o(busy), .fifo_free_o(fifo_free)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // R2 size launch; R7/R9 busy duration when queue empty
  task automatic launch(input int w, input int h);
    int cyc = 0;
    wr(1, {16'(w), 16'(h)});
    while (busy) begin cyc++; @(negedge clk); end
    check("R7 busy cycles", cyc, 2 * w * h + 1);
  endtask

  task automatic check_fb(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      host_addr = 10'(a);
      #0.1;
      check(req, int'(host_pix), int'(model[a]));
    end
  endtask

  task automatic model_fill(input int x, input int y, input int w, input int h,
                            input logic [7:0] c, input logic [7:0] m);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        model[(y + j) * PITCH + x + i] = (model[(y + j) * PITCH + x + i] & ~m) | (c & m);
  endtask

  task automatic do_fill(input int x, input int y, input int w, input int h,
                         input logic [7:0] c, input logic [7:0] m);
    wr(7, 0); wr(2, 3); wr(5, 32'(c)); wr(6, 32'(m));
    wr(0, {16'(x), 16'(y)});
    launch(w, h);
    model_fill(x, y, w, h, c, m);
  endtask

  // R4/R5: direction chosen by the overlap rule, far-edge start on reversed axes
  task automatic do_copy(input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h, input logic [7:0] m);
    bit right = (dx <= sx);
    bit down  = (dy <= sy);
    int ox = right ? 0 : w - 1;
    int oy = down  ? 0 : h - 1;
    wr(7, 1); wr(6, 32'(m));
    wr(2, {30'd0, down, right});
    wr(3, {16'(sx + ox), 16'(sy + oy)});
    wr(0, {16'(dx + ox), 16'(dy + oy)});
    launch(w, h);
    for (int a = 0; a < DEPTH; a++) snap[a] = model[a];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        model[(dy + j) * PITCH + dx + i] =
          (model[(dy + j) * PITCH + dx + i] & ~m) | (snap[(sy + j) * PITCH + sx + i] & m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 fifo free", int'(fifo_free), 16);
    check_fb("R1 fb zero");

    // R2 pitch field in bits 31:22
    wr(4, 32'(PITCH) << 22);
    wait_idle();

    // R3 plain fill
    do_fill(2, 3, 5, 4, 8'h5A, 8'hFF);
    check_fb("R3 fill");
    // R6 masked fill over the previous one
    do_fill(4, 4, 6, 3, 8'hA3, 8'h0F);
    check_fb("R6 masked fill");

    // varied source pattern: one colour per column, plus a row band
    for (int i = 0; i < 10; i++) do_fill(i + 1, 2, 1, 9, 8'(8'h10 + i * 7), 8'hFF);
    do_fill(0, 6, 12, 2, 8'hC0, 8'hF0);
    check_fb("R3 pattern");

    // R4 non-overlapping forward copy
    do_copy(1, 2, 18, 12, 8, 7, 8'hFF);
    check_fb("R4 copy");
    // R5 overlap, destination right of source: x reversed
    do_copy(1, 2, 4, 2, 8, 6, 8'hFF);
    check_fb("R5 overlap x");
    // R5 overlap, destination below source: y reversed
    do_copy(2, 3, 2, 6, 7, 6, 8'hFF);
    check_fb("R5 overlap y");
    // R5 overlap, destination below-right: both reversed
    do_copy(18, 12, 20, 14, 8, 7, 8'hFF);
    check_fb("R5 overlap xy");
    // R5 overlap, destination up-left: both forward
    do_copy(5, 6, 3, 4, 9, 8, 8'hFF);
    check_fb("R5 overlap fwd");
    // R6 masked copy
    do_copy(18, 12, 0, 20, 10, 6, 8'hF0);
    check_fb("R6 masked copy");

    // R9 zero width and zero height
    wr(7, 0); wr(5, 8'hEE); wr(6, 8'hFF); wr(0, {16'd5, 16'd5});
    launch(0, 5);
    launch(5, 0);
    check_fb("R9 empty rect");

    // R8 queue during a long fill
    wr(7, 0); wr(2, 3); wr(5, 8'h11); wr(6, 8'hFF); wr(0, 0);
    wr(1, {16'd32, 16'd32});
    wr(6, 8'hFF); wr(5, 8'h77); wr(0, {16'd3, 16'd7}); wr(1, {16'd5, 16'd2});
    check("R8 fifo free", int'(fifo_free), 12);
    check("R8 busy", int'(busy), 1);
    wait_idle();
    check("R8 fifo drained", int'(fifo_free), 16);
    model_fill(0, 0, 32, 32, 8'h11, 8'hFF);
    model_fill(3, 7, 5, 2, 8'h77, 8'hFF);
    check_fb("R8 queued order");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule